// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer

This block sits on the controller side of a synchronous DRAM. After reset it drives the memory's command pins through the steps the memory needs before it accepts normal traffic. First it keeps the bus quiet, with chip select high and clock enable low, until the supply has been stable for a set time. It can then open a short connectivity-test window. After that it raises clock enable, precharges all banks, issues a set number of auto-refresh commands and writes the mode register. The gaps between commands are programmable and are filled with NOPs.

The power-stable wait is given as a clock frequency in MHz times a wait time in microseconds, so 100 MHz and 100 us give 10000 cycles. The test window is taken unless the `skip_test` input is high when the wait ends. The mode-register value comes from an input. When the last gap has elapsed the `done` flag rises and stays high until the next reset. All pin outputs are registered, so each output follows the internal state by one clock.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the outputs show `cke`=0, `cs_n`=1, `done`=0 and `addr`=0.
- R2: For the first STABLE = CLK_MHZ*POWER_WAIT_US clocks after reset is released, the outputs stay deselected (`cs_n`=1) with `cke` low.
- R3: If the window is taken, the test-entry pattern starts on clock STABLE+1 and lasts TEST_CYCLES+1 clocks. The pattern is `cke`=0, `cs_n`=0, `cas_n`=0, `ras_n`=1, `we_n`=1. It is followed by one exit clock with `cke`=0, `cs_n`=1 and `cas_n`=1.
- R4: `skip_test` is sampled only in the last clock of the power wait. When it is high, no test pattern appears, `cke` rises on clock STABLE+1, and the earlier value of `skip_test` has no effect.
- R5: Once `cke` rises it stays high. NOP ({cs_n,ras_n,cas_n,we_n}=0111) is held for CKE_NOP_CYCLES clocks before precharge-all.
- R6: Precharge-all is encoded 0010 with `cke` high and `addr[AP_BIT]` high.
- R7: REFRESH_COUNT auto-refresh commands (encoded 0001) are issued. A count below 2 is raised to 2. The first comes TRP_CYCLES clocks after precharge-all, and each later one comes TRC_CYCLES clocks after the one before.
- R8: Mode register set (encoded 0000) comes TRC_CYCLES clocks after the last refresh. It carries `addr` equal to `mode_word` and `ba`=0.
- R9: `done` rises TMRD_CYCLES clocks after the mode register set and stays high until reset. While `done` is high, only NOP is driven.
- R10: No command other than those listed above ever appears with `cs_n` low.
- R11: A reset in the middle of the sequence returns the outputs to the R1 state. The sequence then restarts with the full power wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_test | input | 1 | High bypasses the test window |
| mode_word | input | ADDR_W | Value written to the mode register |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank select |
| done | output | 1 | Initialization complete |

## Verification
The assertions assume that `mode_word` holds steady during the clock in which the mode register set is being prepared. The mode-register check compares `addr` against the value `mode_word` had one clock earlier. They also assume that reset is held for at least one full clock, so the registered pins leave their unknown state before any property is evaluated. The stimulus changes inputs only on falling clock edges and keeps `mode_word` constant for a whole run. `skip_test` is also held constant, except in the one run that flips it a few clocks before the power wait ends, to show that only its last-clock value counts.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_TENTER,
        ST_TRUN,
        ST_TEXIT,
        ST_CKEUP,
        ST_PALL,
        ST_TRP,
        ST_REF,
        ST_TRC,
        ST_MRS,
        ST_TMRD,
        ST_DONE
    } init_state_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PIN_QUIET = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pin_cmd_t PIN_TEST  = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam pin_cmd_t PIN_NOP   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pin_cmd_t PIN_PALL  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam pin_cmd_t PIN_REF   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam pin_cmd_t PIN_MRS   = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern driven while the sequencer sits in a given state.
    function automatic pin_cmd_t pins_for(input init_state_e s);
        pin_cmd_t p;
        case (s)
            ST_PWR:              p = PIN_QUIET;
            ST_TENTER, ST_TRUN:  p = PIN_TEST;
            ST_TEXIT:            p = PIN_QUIET;
            ST_PALL:             p = PIN_PALL;
            ST_REF:              p = PIN_REF;
            ST_MRS:              p = PIN_MRS;
            default:             p = PIN_NOP;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CW      = 14,
    parameter int RST_VAL = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CW'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // The state holding this count leaves on the clock where one remains.
    assign expired = (cnt_q <= CW'(1));

endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
    import sdram_init_pkg::*;
#(
    parameter int STABLE  = 10000,
    parameter int TEST    = 16,
    parameter int CKE_NOP = 2,
    parameter int TRP     = 3,
    parameter int TRC     = 7,
    parameter int TMRD    = 2,
    parameter int REFS    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        skip_test,
    output init_state_e state
);
    // Lengths of timed states, in clocks spent in that state.
    localparam int PWR_L  = imax(STABLE, 1);
    localparam int TEST_L = imax(TEST, 1);
    localparam int CKE_L  = imax(CKE_NOP, 1);
    localparam int TRP_L  = imax(TRP, 2) - 1;
    localparam int TRC_L  = imax(TRC, 2) - 1;
    localparam int TMRD_L = imax(TMRD, 2) - 1;
    localparam int REF_N  = imax(REFS, 2);
    localparam int LMAX   = imax(imax(PWR_L, TEST_L), imax(imax(CKE_L, TRP_L), imax(TRC_L, TMRD_L)));
    localparam int CW     = $clog2(LMAX + 1);
    localparam int RW     = $clog2(REF_N + 1);

    init_state_e   state_q, state_d;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    logic [RW-1:0] refs_left;

    sdram_init_timer #(.CW(CW), .RST_VAL(PWR_L)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PWR:    if (expired) state_d = skip_test ? ST_CKEUP : ST_TENTER;
            ST_TENTER: state_d = ST_TRUN;
            ST_TRUN:   if (expired) state_d = ST_TEXIT;
            ST_TEXIT:  state_d = ST_CKEUP;
            ST_CKEUP:  if (expired) state_d = ST_PALL;
            ST_PALL:   state_d = ST_TRP;
            ST_TRP:    if (expired) state_d = ST_REF;
            ST_REF:    state_d = ST_TRC;
            ST_TRC:    if (expired) state_d = (refs_left == '0) ? ST_MRS : ST_REF;
            ST_MRS:    state_d = ST_TMRD;
            ST_TMRD:   if (expired) state_d = ST_DONE;
            ST_DONE:   state_d = ST_DONE;
            default:   state_d = ST_PWR;
        endcase
    end

    always_comb begin
        load = (state_d != state_q);
        case (state_d)
            ST_TRUN:  load_val = CW'(TEST_L);
            ST_CKEUP: load_val = CW'(CKE_L);
            ST_TRP:   load_val = CW'(TRP_L);
            ST_TRC:   load_val = CW'(TRC_L);
            ST_TMRD:  load_val = CW'(TMRD_L);
            default:  load_val = CW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_PWR;
            refs_left <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PALL) begin
                refs_left <= RW'(REF_N);
            end else if (state_q == ST_REF) begin
                refs_left <= refs_left - RW'(1);
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/sdram_init_cmdgen.sv
module sdram_init_cmdgen
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  init_state_e       state,
    input  logic [ADDR_W-1:0] mode_word,
    output pin_cmd_t          pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = '0;
        if (state == ST_PALL) begin
            addr_d[AP_BIT] = 1'b1;
        end else if (state == ST_MRS) begin
            addr_d = mode_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins <= PIN_QUIET;
            addr <= '0;
            ba   <= '0;
            done <= 1'b0;
        end else begin
            pins <= pins_for(state);
            addr <= addr_d;
            ba   <= '0;
            done <= (state == ST_DONE);
        end
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ         = 100,
    parameter int POWER_WAIT_US   = 100,
    parameter int TEST_CYCLES     = 16,
    parameter int CKE_NOP_CYCLES  = 2,
    parameter int TRP_CYCLES      = 3,
    parameter int TRC_CYCLES      = 7,
    parameter int TMRD_CYCLES     = 2,
    parameter int REFRESH_COUNT   = 2,
    parameter int ADDR_W          = 11,
    parameter int BA_W            = 2,
    parameter int AP_BIT          = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              skip_test,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);
    localparam int STABLE = CLK_MHZ * POWER_WAIT_US;

    init_state_e state;
    pin_cmd_t    pins;

    sdram_init_ctrl #(
        .STABLE  (STABLE),
        .TEST    (TEST_CYCLES),
        .CKE_NOP (CKE_NOP_CYCLES),
        .TRP     (TRP_CYCLES),
        .TRC     (TRC_CYCLES),
        .TMRD    (TMRD_CYCLES),
        .REFS    (REFRESH_COUNT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .skip_test (skip_test),
        .state     (state)
    );

    sdram_init_cmdgen #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .AP_BIT (AP_BIT)
    ) u_cmdgen (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .mode_word (mode_word),
        .pins      (pins),
        .addr      (addr),
        .ba        (ba),
        .done      (done)
    );

    assign cke   = pins.cke;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mode_word,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              done
);
    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    p_cke_low_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (ras_n && we_n));

    p_test_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (!cke && $rose(cas_n)) |-> cs_n);

    p_cke_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_pall_a10_r6: assert property (@(posedge clk) disable iff (rst)
        (cke && cmd == 4'b0010) |-> addr[AP_BIT]);

    p_mrs_word_r8: assert property (@(posedge clk) disable iff (rst)
        (cke && cmd == 4'b0000) |-> (addr == $past(mode_word) && ba == '0));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_nop_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (cke && cmd == 4'b0111));

    p_cmd_legal_r10: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> ((!cke && cmd == 4'b0101) ||
                   (cke && (cmd == 4'b0111 || cmd == 4'b0010 ||
                            cmd == 4'b0001 || cmd == 4'b0000))));

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .AP_BIT (AP_BIT)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_word (mode_word),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .done      (done)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;
    localparam int CLK_MHZ = 1;
    localparam int WAIT_US = 20;
    localparam int STABLE  = CLK_MHZ * WAIT_US;
    localparam int TEST    = 4;
    localparam int CKEN    = 3;
    localparam int TRP     = 3;
    localparam int TRC     = 5;
    localparam int TMRD    = 2;
    localparam int REFS    = 3;
    localparam int ADDR_W  = 11;
    localparam int BA_W    = 2;
    localparam int AP      = 10;

    // Expected event clocks, counted from the first edge after reset release.
    localparam int EN_C  = STABLE + 1;
    localparam int EX_C  = EN_C + 1 + TEST;
    localparam int PA_C  = EX_C + 1 + CKEN;
    localparam int RF0_C = PA_C + TRP;
    localparam int MR_C  = RF0_C + REFS * TRC;
    localparam int DN_C  = MR_C + TMRD;
    localparam int SHIFT = 2 + TEST;
    localparam int RUN_LEN = DN_C + 20;

    // Event codes: 1 test entry, 2 test exit, 3 precharge-all, 4 refresh, 5 mode set, 6 done rise
    localparam int NEV = 8;
    localparam int TAB_CODE [NEV] = '{1, 2, 3, 4, 4, 4, 5, 6};
    localparam int TAB_CYC  [NEV] = '{EN_C, EX_C, PA_C, RF0_C, RF0_C + TRC, RF0_C + 2*TRC, MR_C, DN_C};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              skip_test = 1'b0;
    logic [ADDR_W-1:0] mode_word = '0;
    logic              cke, cs_n, ras_n, cas_n, we_n, done;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;

    int checks = 0;
    int errors = 0;
    int cyc;
    int nev;
    int ev_code [32];
    int ev_cyc  [32];
    int cke_rise;
    bit prev_test, prev_done, quiet_bad, done_drop;

    sdram_pwrup_seq #(
        .CLK_MHZ        (CLK_MHZ),
        .POWER_WAIT_US  (WAIT_US),
        .TEST_CYCLES    (TEST),
        .CKE_NOP_CYCLES (CKEN),
        .TRP_CYCLES     (TRP),
        .TRC_CYCLES     (TRC),
        .TMRD_CYCLES    (TMRD),
        .REFRESH_COUNT  (REFS),
        .ADDR_W         (ADDR_W),
        .BA_W           (BA_W),
        .AP_BIT         (AP)
    ) i_sdram_pwrup_seq (
        .clk       (clk),
        .rst       (rst),
        .skip_test (skip_test),
        .mode_word (mode_word),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .done      (done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cke == 1'b0, req, "cke in reset", int'(cke), 0);
        check(cs_n == 1'b1 && done == 1'b0 && addr == '0, req, "cs_n/done/addr in reset",
              int'({cs_n, done}), 2);
        rst = 1'b0;
        cyc = 0; nev = 0; cke_rise = 0;
        prev_test = 1'b0; prev_done = 1'b0; quiet_bad = 1'b0; done_drop = 1'b0;
    endtask

    task automatic record(input int code);
        if (nev < 32) begin
            ev_code[nev] = code;
            ev_cyc[nev]  = cyc;
        end
        nev++;
    endtask

    task automatic observe(input int n, input int flip_at);
        for (int i = 0; i < n; i++) begin
            bit test_pat, exit_pat;
            logic [3:0] cmd;
            @(posedge clk);
            @(negedge clk);
            cyc++;
            cmd      = {cs_n, ras_n, cas_n, we_n};
            test_pat = !cke && !cs_n && !cas_n && ras_n && we_n;
            exit_pat = !cke && cs_n && cas_n;
            if (cyc <= STABLE && !(cs_n && !cke)) quiet_bad = 1'b1;
            if (cke && cke_rise == 0) cke_rise = cyc;
            if (test_pat) begin
                if (!prev_test) record(1);
            end else if (exit_pat && prev_test) begin
                record(2);
            end else if (cke && cmd == 4'b0010) begin
                record(3);
                check(addr[AP] == 1'b1, "R6", "A10 at precharge-all", int'(addr[AP]), 1);
            end else if (cke && cmd == 4'b0001) begin
                record(4);
            end else if (cke && cmd == 4'b0000) begin
                record(5);
                check(addr == mode_word && ba == '0, "R8", "mode set address",
                      int'(addr), int'(mode_word));
            end else if (!(cs_n || cmd == 4'b0111)) begin
                record(7);
            end
            if (done && !prev_done) record(6);
            if (prev_done && !done) done_drop = 1'b1;
            prev_test = test_pat;
            prev_done = done;
            if (flip_at != 0 && cyc == flip_at) skip_test = ~skip_test;
        end
    endtask

    function automatic string req_of(input int code, input bit skip);
        case (code)
            1, 2:    return "R3";
            3:       return skip ? "R4" : "R5";
            4:       return "R7";
            5:       return "R8";
            6:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic compare(input bit skip, input string tag);
        int k = 0;
        for (int i = 0; i < NEV; i++) begin
            int exp_cyc;
            if (skip && TAB_CODE[i] <= 2) continue;
            exp_cyc = skip ? TAB_CYC[i] - SHIFT : TAB_CYC[i];
            check(k < nev && ev_code[k] == TAB_CODE[i], req_of(TAB_CODE[i], skip),
                  {tag, " event code"}, (k < nev) ? ev_code[k] : -1, TAB_CODE[i]);
            check(k < nev && ev_cyc[k] == exp_cyc, req_of(TAB_CODE[i], skip),
                  {tag, " event clock"}, (k < nev) ? ev_cyc[k] : -1, exp_cyc);
            k++;
        end
        check(nev == k, "R10", {tag, " number of commands"}, nev, k);
        check(!quiet_bad, "R2", {tag, " quiet during power wait"}, int'(quiet_bad), 0);
        check(!done_drop, "R9", {tag, " done stays high"}, int'(done_drop), 0);
        check(cke_rise == (skip ? STABLE + 1 : EX_C + 1), "R5", {tag, " cke rise clock"},
              cke_rise, skip ? STABLE + 1 : EX_C + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Full sequence with the test window (R1, R2, R3, R5-R10)
        skip_test = 1'b0;
        mode_word = 11'h233;
        do_reset("R1");
        observe(RUN_LEN, 0);
        compare(1'b0, "window");

        // Window bypassed (R4)
        skip_test = 1'b1;
        mode_word = 11'h037;
        do_reset("R1");
        observe(RUN_LEN, 0);
        compare(1'b1, "skip");

        // R4: skip_test high early, low in the last wait clock -> window is taken
        skip_test = 1'b1;
        mode_word = 11'h4A5;
        do_reset("R1");
        observe(RUN_LEN, STABLE - 3);
        compare(1'b0, "late-skip-low");

        // R11: reset in the middle of the sequence, then full restart
        skip_test = 1'b0;
        mode_word = 11'h7FF;
        do_reset("R1");
        observe(PA_C + 4, 0);
        do_reset("R11");
        observe(RUN_LEN, 0);
        compare(1'b0, "R11 restart");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule